// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block sequences a successive-approximation converter. It divides the system clock down to a conversion clock tick and decides when the acquisition phase ends and a conversion begins. A conversion lasts a fixed fourteen conversion-clock periods and then writes the converter's data word into a result register. Three start sources are available. In software mode the start comes from a falling edge on a sample bit. In auto mode the block counts a programmed number of conversion-clock periods of acquisition. In external mode a timer or interrupt pulse starts the conversion.

The block is clocked at twice the instruction rate. The conversion clock period is therefore (divider + 1) system clocks. Dropping the enable bit aborts a conversion in progress. An aborted conversion leaves the result register untouched, and sequencing stays halted until a fresh trigger arrives after the block is enabled again. In auto mode acquisition restarts by itself after every completed conversion, so sampling runs without gaps while the block is enabled. The analog converter is outside this block: its output word simply appears on an input port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `result_o` is 0 and both `done_o` and `busy_o` are low.
- R2: With divider value D on `clk_div_i`, the conversion clock ticks every D+1 clocks. The divider restarts at each conversion start, so `busy_o` stays high for exactly 14*(D+1) cycles.
- R3: With `trig_sel_i` = 3'b000 (software mode), a conversion starts in the first cycle in which `sample_i` is low after having been high. `busy_o` is visible high in the next cycle.
- R4: With `trig_sel_i` = 3'b111 (auto mode) and sample count N on `acq_cnt_i`, `busy_o` rises N*(D+1) cycles after acquisition begins. Acquisition begins in the first enabled cycle. A count of 0 behaves as 1.
- R5: With `trig_sel_i` at any value from 3'b001 to 3'b110 (external mode), a conversion starts in the cycle in which `ext_trig_i` is high. `busy_o` is visible high in the next cycle.
- R6: While `busy_o` is high, all trigger inputs are ignored. The running conversion keeps its length, and no start is queued for later.
- R7: When a conversion completes, `done_o` pulses high for one cycle. In that same cycle `busy_o` falls and `result_o` shows the value `conv_data_i` held in the cycle before.
- R8: If `enable_i` is low while a conversion runs, `busy_o` drops in the next cycle, `done_o` never pulses and `result_o` keeps its previous value. After re-enable, no conversion starts without a new trigger.
- R9: If `enable_i` falls in the very cycle in which an auto-mode start would occur, no conversion starts.
- R10: In auto mode, a new acquisition begins in the cycle `done_o` is high. The next `busy_o` rise follows N*(D+1) cycles after that cycle.
- R11: The divider and the acquisition counter are cleared while disabled. After re-enable, the first tick therefore comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the instruction rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable; low aborts and clears sequencing |
| sample_i | input | 1 | Software sample bit; a 1-to-0 change starts a conversion in software mode |
| trig_sel_i | input | 3 | Start source: 000 software, 111 auto, others external |
| acq_cnt_i | input | 5 | Auto-mode acquisition length in conversion-clock periods (0 acts as 1) |
| clk_div_i | input | 6 | Conversion clock divider; period is value+1 clocks |
| ext_trig_i | input | 1 | External timer or interrupt start pulse |
| conv_data_i | input | 12 | Data word from the converter |
| result_o | output | 12 | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when the result register is written |
| busy_o | output | 1 | High while a conversion is in progress |

## Verification
Two events can fall in the same cycle: an auto-mode conversion start on a divider tick, and the enable bit being cleared. The bench provokes this by enabling auto mode with a known divider and sample count. It then clears the enable at exactly N*(D+1)-1 negative edges after the enable, which is the cycle of the start, and expects `busy_o` and `done_o` to stay low for the following conversion length. A second overlap is a trigger arriving while a conversion is running. The bench judges it by the exact busy length and by the absence of any follow-on conversion.

// File: rtl/adcseq_pkg.sv
// Shared types for the ADC sequencer.
// Assumes: the 3-bit start-source code keeps 000 as software and 111 as auto.
package adcseq_pkg;

    // Number of conversion-clock periods in one conversion
    localparam int unsigned CONV_TICKS_DEF = 14;

    typedef enum logic [1:0] {
        TRIG_SOFT = 2'd0,
        TRIG_EXT  = 2'd1,
        TRIG_AUTO = 2'd2
    } trig_mode_e;

    // Map the raw 3-bit select onto a start-source class
    function automatic trig_mode_e decode_trig(input logic [2:0] sel);
        if (sel == 3'b000)
            return TRIG_SOFT;
        else if (sel == 3'b111)
            return TRIG_AUTO;
        else
            return TRIG_EXT;
    endfunction

endpackage

// File: rtl/adcseq_tick_gen.sv
// Conversion clock divider: asserts tick_o once every div_i+1 clocks.
// Assumes: the counter is held at zero while run_i is low, and restart_i
// realigns the period so that the next tick comes a full period later.
module adcseq_tick_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Tick when the count reaches the divider (>= guards a lowered setting)
    assign tick_o = run_i && (cnt_q >= div_i);

    // Period counter: cleared when idle, on restart and on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || restart_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R2

endmodule

// File: rtl/adcseq_start_sel.sv
// Start-source selector: decides the cycle in which acquisition ends and
// a conversion begins, for software, auto and external modes.
// Assumes: start_o is consumed combinationally by the divider and timer;
// it is only raised while enabled and idle.
module adcseq_start_sel
    import adcseq_pkg::*;
#(
    parameter int SAMC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              busy_i,
    input  logic              tick_i,
    input  trig_mode_e        mode_i,
    input  logic              samp_i,
    input  logic              ext_i,
    input  logic [SAMC_W-1:0] samc_i,
    output logic              start_o
);

    logic              samp_q;
    logic [SAMC_W-1:0] acq_q;
    logic [SAMC_W-1:0] acq_last;
    logic              armed;
    logic              hit;

    // Last acquisition tick index; a zero count behaves as one
    assign acq_last = (samc_i == '0) ? '0 : samc_i - 1'b1;
    assign armed    = en_i && !busy_i;

    // Per-mode start condition
    always_comb begin
        unique case (mode_i)
            TRIG_SOFT: hit = samp_q && !samp_i;
            TRIG_AUTO: hit = tick_i && (acq_q >= acq_last);
            default:   hit = ext_i;
        endcase
    end

    assign start_o = armed && hit;

    // Previous sample bit for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            samp_q <= 1'b0;
        else
            samp_q <= samp_i;
    end

    // Acquisition period counter for auto mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_q <= '0;
        else if (!armed || mode_i != TRIG_AUTO || start_o)
            acq_q <= '0;
        else if (tick_i)
            acq_q <= acq_q + 1'b1;
    end

    AST_SOFT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && mode_i == TRIG_SOFT) |-> ($past(samp_i) && !samp_i)); // R3

endmodule

// File: rtl/adcseq_conv_timer.sv
// Conversion timer: holds busy for TICKS conversion-clock periods, then
// raises a write strobe and a registered done pulse.
// Assumes: start_i only arrives while idle; a low en_i aborts at once.
module adcseq_conv_timer #(
    parameter int TICKS = 14,
    localparam int CW   = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic tick_i,
    output logic write_o,
    output logic busy_o,
    output logic done_o
);

    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;

    // Final tick of a conversion that is still enabled
    assign write_o = busy_q && en_i && tick_i && (cnt_q == LAST);

    // Busy state: set on start, cleared on completion or abort
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (!en_i)
            busy_q <= 1'b0;
        else if (start_i)
            busy_q <= 1'b1;
        else if (write_o)
            busy_q <= 1'b0;
    end

    // Tick counter within a conversion
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!busy_q || !en_i || write_o)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= write_o;
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= LAST)); // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start_i); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !en_i) |=> (!busy_q && !done_q)); // R8

endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC sample and conversion sequencer top: ties the divider, start
// selector and conversion timer together and owns the result register.
// Assumes: conv_data_i is valid in the cycle of the last conversion tick.
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int DIV_W      = 6,
    parameter int SAMC_W     = 5,
    parameter int CONV_TICKS = CONV_TICKS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              sample_i,
    input  logic [2:0]        trig_sel_i,
    input  logic [SAMC_W-1:0] acq_cnt_i,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic              ext_trig_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              busy_o
);

    trig_mode_e        mode;
    logic              tick;
    logic              start;
    logic              write;
    logic              busy;
    logic [DATA_W-1:0] result_q;

    assign mode = decode_trig(trig_sel_i);

    adcseq_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (enable_i),
        .restart_i (start),
        .div_i     (clk_div_i),
        .tick_o    (tick)
    );

    adcseq_start_sel #(.SAMC_W(SAMC_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .busy_i  (busy),
        .tick_i  (tick),
        .mode_i  (mode),
        .samp_i  (sample_i),
        .ext_i   (ext_trig_i),
        .samc_i  (acq_cnt_i),
        .start_o (start)
    );

    adcseq_conv_timer #(.TICKS(CONV_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .start_i (start),
        .tick_i  (tick),
        .write_o (write),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    // Result register: loaded only by a completed conversion
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (write)
            result_q <= conv_data_i;
    end

    assign result_o = result_q;
    assign busy_o   = busy;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !write |=> $stable(result_o)); // R8
    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !start); // R9
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          samp = 1'b0;
    logic          ext = 1'b0;
    logic [2:0]    tsel = 3'd0;
    logic [4:0]    samc = 5'd0;
    logic [5:0]    adcs = 6'd0;
    logic [DW-1:0] data = '0;
    logic [DW-1:0] result;
    logic          done;
    logic          busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (en),
        .sample_i    (samp),
        .trig_sel_i  (tsel),
        .acq_cnt_i   (samc),
        .clk_div_i   (adcs),
        .ext_trig_i  (ext),
        .conv_data_i (data),
        .result_o    (result),
        .done_o      (done),
        .busy_o      (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int conv_len(input int d);
        return 14 * (d + 1);
    endfunction

    function automatic int acq_len(input int n, input int d);
        return ((n == 0) ? 1 : n) * (d + 1);
    endfunction

    task automatic wait_busy(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!busy && k < 4000);
    endtask

    // Called at the first negedge showing busy high
    task automatic finish_conv(input string req, input int d, input int expd);
        int len = 0;
        while (busy && len < 4000) begin
            len++;
            @(negedge clk);
        end
        chk(len == conv_len(d), req, len, conv_len(d));
        chk(done == 1'b1, "R7 done", int'(done), 1);
        chk(int'(result) == expd, "R7 result", int'(result), expd);
    endtask

    task automatic go_idle();
        @(negedge clk);
        en = 1'b0; samp = 1'b0; ext = 1'b0;
        @(negedge clk);
    endtask

    task automatic soft_conv(input int d, input int dat);
        go_idle();
        tsel = 3'b000; adcs = 6'(d); data = DW'(dat); en = 1'b1; samp = 1'b1;
        @(negedge clk); @(negedge clk);
        samp = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R3 start", int'(busy), 1);
        finish_conv("R2 soft length", d, dat);
        @(negedge clk);
        chk(done == 1'b0, "R7 pulse width", int'(done), 0);
    endtask

    task automatic ext_conv(input int d, input int sel, input int dat);
        go_idle();
        tsel = 3'(sel); adcs = 6'(d); data = DW'(dat); en = 1'b1;
        @(negedge clk); @(negedge clk);
        ext = 1'b1;
        @(negedge clk);
        ext = 1'b0;
        chk(busy == 1'b1, "R5 start", int'(busy), 1);
        finish_conv("R2 ext length", d, dat);
    endtask

    task automatic auto_conv(input int d, input int n, input int dat, input int rounds);
        int k;
        go_idle();
        tsel = 3'b111; adcs = 6'(d); samc = 5'(n); data = DW'(dat); en = 1'b1;
        wait_busy(k);
        chk(k == acq_len(n, d), "R4 acquisition", k, acq_len(n, d));
        finish_conv("R2 auto length", d, dat);
        for (int r = 1; r < rounds; r++) begin
            data = DW'(dat + r);
            wait_busy(k);
            chk(k == acq_len(n, d), "R10 restart", k, acq_len(n, d));
            finish_conv("R2 auto length", d, (dat + r) & 'hFFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k;
        int cnt;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(result == '0, "R1 result", int'(result), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);

        // Directed corners: divider extremes and zero sample count
        soft_conv(0, 'h5A5);
        soft_conv(63, 'h123);
        ext_conv(2, 3'b011, 'hABC);
        auto_conv(2, 0, 'h0F0, 2);
        auto_conv(0, 31, 'h700, 2);
        auto_conv(0, 1, 'h010, 3);

        // R6: triggers during a conversion are ignored, nothing is queued
        go_idle();
        tsel = 3'b101; adcs = 6'd1; data = 'h321; en = 1'b1;
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        repeat (5) @(negedge clk);
        ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        cnt = 6;
        while (busy && cnt < 4000) begin cnt++; @(negedge clk); end
        chk(cnt == conv_len(1), "R6 busy length", cnt, conv_len(1));
        cnt = 0;
        repeat (30) begin @(negedge clk); if (busy) cnt++; end
        chk(cnt == 0, "R6 no queued start", cnt, 0);

        // R8: abort keeps the old result and waits for a new trigger
        soft_conv(1, 'h2AA);
        go_idle();
        tsel = 3'b000; adcs = 6'd1; data = 'h155; en = 1'b1; samp = 1'b1;
        @(negedge clk); @(negedge clk);
        samp = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy drop", int'(busy), 0);
        cnt = 0;
        repeat (conv_len(1) + 5) begin @(negedge clk); if (done) cnt++; end
        chk(cnt == 0, "R8 no done", cnt, 0);
        chk(int'(result) == 'h2AA, "R8 result kept", int'(result), 'h2AA);
        en = 1'b1;
        cnt = 0;
        repeat (40) begin @(negedge clk); if (busy) cnt++; end
        chk(cnt == 0, "R8 halted", cnt, 0);

        // R9: disable in the exact cycle of an auto start
        go_idle();
        tsel = 3'b111; adcs = 6'd3; samc = 5'd2; data = 'h777; en = 1'b1;
        repeat (acq_len(2, 3) - 1) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 no start", int'(busy), 0);
        cnt = 0;
        repeat (conv_len(3) + 5) begin @(negedge clk); if (busy || done) cnt++; end
        chk(cnt == 0, "R9 quiet", cnt, 0);
        chk(int'(result) == 'h2AA, "R9 result kept", int'(result), 'h2AA);

        // R11: a short disable clears the divider and acquisition count
        go_idle();
        tsel = 3'b111; adcs = 6'd4; samc = 5'd1; en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        wait_busy(k);
        chk(k == acq_len(1, 4), "R11 full period", k, acq_len(1, 4));

        // Random mix of modes and settings
        for (int i = 0; i < 12; i++) begin
            int m = int'($urandom % 3);
            int d = int'($urandom % 6);
            int n = int'($urandom % 4);
            int dat = int'($urandom % 4096);
            int sel = 1 + int'($urandom % 6);
            if (m == 0)
                soft_conv(d, dat);
            else if (m == 1)
                ext_conv(d, sel, dat);
            else
                auto_conv(d, n, dat, 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule